// File: doc/BRIEF.md
# Age-Ordered Collapsing Instruction Window

This block is the waiting room between dispatch and one functional unit. Each dispatched instruction brings an opcode, a destination tag and two source tags. Each source tag comes with a flag that says whether that operand already exists. The entry stays in the window until both operands are marked present. Two result buses announce finished tags. Every stored source compares itself against both buses, and a match sets its ready flag.

Position in the window is age. The oldest instruction sits at slot 0, and each new arrival is written just above the highest occupied slot. When an instruction leaves, everything above it moves down one slot, so the occupied slots always form one unbroken run from slot 0. Selection is a plain search for the lowest-numbered ready slot, which makes the oldest ready instruction the winner. Ready flags are registered. A tag announced in one cycle therefore makes its consumer selectable in the very next cycle, and a dependent instruction can follow its producer back to back.

Both data edges use valid/ready handshakes. On the dispatch side the window sets `dsp_ready` low while all slots are occupied, and a transfer happens only on a cycle where `dsp_valid` and `dsp_ready` are both high. On the issue side `iss_valid` is driven from stored state alone and never depends on `iss_ready`. The instruction leaves on a cycle where both signals are high. While `iss_ready` is low, an offered instruction stays offered, although an older instruction may take its place once it becomes ready.

Top module: `iq_compact`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, the window is empty: `iss_valid`=0, `full`=0, `dsp_ready`=1.
- R2: `full` is 1 exactly when all DEPTH (16) slots are occupied, and `dsp_ready` is its inverse. A dispatch offered while the window is full is dropped and never issues.
- R3: `iss_valid` is 1 only when some stored instruction has both ready flags set. The transfer on a cycle with `iss_valid` and `iss_ready` both high removes that instruction.
- R4: When several instructions are ready, the one dispatched earliest is offered first.
- R5: After a removal, the remaining instructions keep their relative age order. A dispatch in the same cycle as an issue is placed above all instructions that remain.
- R6: A tag on either result bus (`bc_valid[b]`=1, `bc_tag[b*TAG_W +: TAG_W]`) sets every matching stored source flag. The consumer becomes selectable in the next cycle, not in the cycle of the broadcast.
- R7: A tag broadcast in the same cycle an instruction is dispatched sets the matching source flags of that instruction.
- R8: While `iss_valid`=1, `iss_ready`=0 and `flush`=0, `iss_valid` stays 1 in the next cycle.
- R9: `flush` clears every slot and overrides a dispatch offered in the same cycle.
- R10: An instruction dispatched with both operands already present is offered in the cycle after its dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all slots |
| dsp_valid | input | 1 | Dispatch offer |
| dsp_ready | output | 1 | Window can accept a dispatch |
| dsp_op | input | OP_W (5) | Opcode of the offered instruction |
| dsp_dst | input | TAG_W (6) | Destination tag |
| dsp_s1 | input | TAG_W (6) | First source tag |
| dsp_r1 | input | 1 | First source already present |
| dsp_s2 | input | TAG_W (6) | Second source tag |
| dsp_r2 | input | 1 | Second source already present |
| bc_valid | input | NBUS (2) | Per-bus broadcast strobe |
| bc_tag | input | NBUS*TAG_W (12) | Broadcast tags, bus b in bits b*TAG_W upward |
| iss_valid | output | 1 | An instruction is offered to the unit |
| iss_ready | input | 1 | Functional unit accepts this cycle |
| iss_op | output | OP_W (5) | Opcode of the offered instruction |
| iss_dst | output | TAG_W (6) | Destination tag of the offered instruction |
| full | output | 1 | All slots occupied |

## Verification
The bench uses the default build: 16 slots, two result buses, 6-bit tags and 5-bit opcodes. With 16 slots the full condition and the dropped seventeenth dispatch take only a short burst to reach. A single broadcast then wakes all sixteen slots at once, and draining them checks the age order through every slot. Having two buses allows tests in which both operands of one instruction wake in the same cycle, each on a different bus, and in which one operand wakes in the very cycle its instruction is dispatched.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int unsigned OP_W  = 5;
  parameter int unsigned TAG_W = 6;

  typedef struct packed {
    logic             vld;
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] s1;
    logic             r1;
    logic [TAG_W-1:0] s2;
    logic             r2;
  } iq_ent_t;
endpackage

// File: rtl/iq_wake.sv
// Applies the result-bus tag matches to one slot's source flags.
module iq_wake
  import iq_pkg::*;
#(
  parameter int unsigned NBUS = 2
) (
  input  iq_ent_t                     ent_in,
  input  logic [NBUS-1:0]             bc_valid,
  input  logic [NBUS-1:0][TAG_W-1:0]  bc_tag,
  output iq_ent_t                     ent_out
);
  always_comb begin
    ent_out = ent_in;
    for (int b = 0; b < int'(NBUS); b++) begin
      if (bc_valid[b] && bc_tag[b] == ent_in.s1) ent_out.r1 = 1'b1;
      if (bc_valid[b] && bc_tag[b] == ent_in.s2) ent_out.r2 = 1'b1;
    end
  end
endmodule

// File: rtl/iq_pick.sv
// Lowest-index request wins: slot position encodes age.
module iq_pick #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/iq_compact.sv
module iq_compact
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NBUS  = 2,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  dsp_valid,
  output logic                  dsp_ready,
  input  logic [OP_W-1:0]       dsp_op,
  input  logic [TAG_W-1:0]      dsp_dst,
  input  logic [TAG_W-1:0]      dsp_s1,
  input  logic                  dsp_r1,
  input  logic [TAG_W-1:0]      dsp_s2,
  input  logic                  dsp_r2,
  input  logic [NBUS-1:0]       bc_valid,
  input  logic [NBUS*TAG_W-1:0] bc_tag,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [OP_W-1:0]       iss_op,
  output logic [TAG_W-1:0]      iss_dst,
  output logic                  full
);
  iq_ent_t q     [DEPTH];
  iq_ent_t nq    [DEPTH];
  iq_ent_t woke  [DEPTH+1];   // index DEPTH is the incoming dispatch
  iq_ent_t incoming;

  logic [NBUS-1:0][TAG_W-1:0] tags;
  logic [DEPTH-1:0]           req;
  logic [DEPTH-1:0]           vld_vec;
  logic [IW-1:0]              sel;
  logic                       any;
  logic [CW-1:0]              cnt;
  logic [CW-1:0]              wpos;
  logic                       fire_i, fire_d;

  generate
    for (genvar b = 0; b < NBUS; b++) begin : g_tag
      assign tags[b] = bc_tag[b*TAG_W +: TAG_W];
    end
  endgenerate

  always_comb begin
    incoming     = '0;
    incoming.vld = 1'b1;
    incoming.op  = dsp_op;
    incoming.dst = dsp_dst;
    incoming.s1  = dsp_s1;
    incoming.r1  = dsp_r1;
    incoming.s2  = dsp_s2;
    incoming.r2  = dsp_r2;
  end

  generate
    for (genvar i = 0; i <= DEPTH; i++) begin : g_wake
      if (i < DEPTH) begin : g_slot
        iq_wake #(.NBUS(NBUS)) u_wake (
          .ent_in(q[i]), .bc_valid(bc_valid), .bc_tag(tags), .ent_out(woke[i]));
        assign req[i]     = q[i].vld & q[i].r1 & q[i].r2;
        assign vld_vec[i] = q[i].vld;
      end else begin : g_new
        iq_wake #(.NBUS(NBUS)) u_wake (
          .ent_in(incoming), .bc_valid(bc_valid), .bc_tag(tags), .ent_out(woke[i]));
      end
    end
  endgenerate

  iq_pick #(.DEPTH(DEPTH)) u_pick (.req(req), .any(any), .idx(sel));

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(DEPTH); i++) cnt = cnt + CW'(vld_vec[i]);
  end

  assign full      = (cnt == CW'(DEPTH));
  assign dsp_ready = ~full;
  assign iss_valid = any;
  assign iss_op    = q[sel].op;
  assign iss_dst   = q[sel].dst;
  assign fire_i    = any & iss_ready;
  assign fire_d    = dsp_valid & dsp_ready;
  assign wpos      = cnt - CW'(fire_i);

  // Collapse above the issued slot, then append the dispatch on top.
  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (fire_i && IW'(i) >= sel)
        nq[i] = (i == int'(DEPTH) - 1) ? iq_ent_t'('0) : woke[i+1];
      else
        nq[i] = woke[i];
      if (fire_d && CW'(i) == wpos) nq[i] = woke[DEPTH];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (!rst_n || flush) q[i] <= '0;
      else                 q[i] <= nq[i];
    end
  end
endmodule

// File: rtl/iq_compact_chk.sv
module iq_compact_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             dsp_valid,
  input logic             dsp_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             full,
  input logic [DEPTH-1:0] vld_vec
);
  // R1: flush empties the window
  a_r1_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_valid && !full && vld_vec == '0));

  // R2: a full window with no issue stays full
  a_r2_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(iss_valid && iss_ready) && !flush) |=> full);

  // R2: an accepted dispatch without an issue adds exactly one slot
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && dsp_ready && !(iss_valid && iss_ready) && !flush)
      |=> $countones(vld_vec) == $past($countones(vld_vec)) + 1);

  // R3: an issue without a dispatch frees exactly one slot
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dsp_valid && dsp_ready) && iss_valid && iss_ready && !flush)
      |=> $countones(vld_vec) == $past($countones(vld_vec)) - 1);

  // R5: occupied slots form an unbroken run from slot 0
  a_r5_no_gaps: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_vec + 1'b1) & vld_vec) == '0);

  // R8: an offer that is not taken persists
  a_r8_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !flush) |=> iss_valid);
endmodule

bind iq_compact iq_compact_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .dsp_valid(dsp_valid),
  .dsp_ready(dsp_ready), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .full(full), .vld_vec(vld_vec));

// File: tb/iq_compact_test.sv
module iq_compact_test;
  logic        clk = 0, rst_n = 0, flush = 0;
  logic        dsp_valid = 0, dsp_ready;
  logic [4:0]  dsp_op = 0;
  logic [5:0]  dsp_dst = 0, dsp_s1 = 0, dsp_s2 = 0;
  logic        dsp_r1 = 0, dsp_r2 = 0;
  logic [1:0]  bc_valid = 0;
  logic [11:0] bc_tag = 0;
  logic        iss_valid, iss_ready = 0, full;
  logic [4:0]  iss_op;
  logic [5:0]  iss_dst;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  iq_compact uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int op, input int s1, input bit r1, input int s2, input bit r2);
    @(negedge clk);
    dsp_valid = 1; dsp_op = 5'(op); dsp_dst = 6'(op);
    dsp_s1 = 6'(s1); dsp_r1 = r1; dsp_s2 = 6'(s2); dsp_r2 = r2;
    @(posedge clk); #1 dsp_valid = 0;
  endtask

  task automatic take(input int op, input string req);
    @(negedge clk); #1;
    chk(req, iss_valid, 1);
    chk(req, iss_op, op);
    iss_ready = 1;
    @(posedge clk); #1 iss_ready = 0;
  endtask

  task automatic bcast(input int bus, input int tag);
    @(negedge clk);
    bc_valid[bus] = 1; bc_tag[bus*6 +: 6] = 6'(tag);
    @(posedge clk); #1 bc_valid = 0;
  endtask

  task automatic peek_valid(input int exp, input string req);
    @(negedge clk); #1 chk(req, iss_valid, exp);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    peek_valid(0, "R1");
    chk("R1", full, 0);
    chk("R1", dsp_ready, 1);
  endtask

  task automatic t_basic;
    put(1, 1, 1, 2, 1);
    peek_valid(1, "R10");
    put(2, 1, 1, 2, 1);
    put(3, 5, 0, 2, 1);
    take(1, "R3");
    take(2, "R3");
    peek_valid(0, "R3");
    // broadcast on bus 1: not selectable in the same cycle
    @(negedge clk);
    bc_valid[1] = 1; bc_tag[11:6] = 6'd5;
    #1 chk("R6", iss_valid, 0);
    @(posedge clk); #1 bc_valid = 0;
    take(3, "R6");
  endtask

  task automatic t_order;
    put(4, 7, 0, 2, 1);
    put(5, 1, 1, 2, 1);
    put(6, 1, 1, 2, 1);
    take(5, "R4");
    bcast(0, 7);
    take(4, "R5");
    // issue op 6 and dispatch op 8 in the same cycle
    @(negedge clk);
    dsp_valid = 1; dsp_op = 8; dsp_s1 = 1; dsp_r1 = 1; dsp_s2 = 2; dsp_r2 = 1;
    iss_ready = 1;
    #1 chk("R5", iss_op, 6);
    @(posedge clk); #1 begin dsp_valid = 0; iss_ready = 0; end
    take(8, "R5");
    peek_valid(0, "R5");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    dsp_valid = 1; dsp_op = 9; dsp_s1 = 9; dsp_r1 = 0; dsp_s2 = 10; dsp_r2 = 0;
    bc_valid = 2'b11; bc_tag = {6'd10, 6'd9};
    @(posedge clk); #1 begin dsp_valid = 0; bc_valid = 0; end
    take(9, "R7");
  endtask

  task automatic t_full;
    for (int k = 0; k < 16; k++) put(k + 10, 20, 0, 2, 1);
    @(negedge clk); #1;
    chk("R2", full, 1);
    chk("R2", dsp_ready, 0);
    put(31, 1, 1, 2, 1);
    bcast(0, 20);
    for (int k = 0; k < 16; k++) take(k + 10, "R4");
    peek_valid(0, "R2");
    chk("R2", full, 0);
  endtask

  task automatic t_hold_flush;
    put(2, 1, 1, 2, 1);
    for (int k = 0; k < 3; k++) peek_valid(1, "R8");
    @(negedge clk);
    flush = 1; dsp_valid = 1; dsp_op = 3; dsp_s1 = 1; dsp_r1 = 1; dsp_s2 = 2; dsp_r2 = 1;
    @(posedge clk); #1 begin flush = 0; dsp_valid = 0; end
    peek_valid(0, "R9");
    chk("R1", full, 0);
    peek_valid(0, "R9");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_same_cycle();
    t_full();
    t_hold_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule